// File: doc/BRIEF.md
# Watchdog Timer with Guarded Turn-Off

This block watches for a periodic service pulse from software. A counter advances once for every tick delivered by an external slow oscillator, and only while the watchdog is enabled. If software lets the count reach the period chosen by a 3-bit prescale code, the block issues a single-cycle system reset request and starts counting again from zero. A service pulse clears the count at any time.

Software reaches the block through a small control register, which it writes and reads back. The register holds an enable bit, a turn-off-enable bit and the prescale code. Software cannot switch the watchdog off with a single careless write. It must first make an unlock write that sets the turn-off-enable bit and the enable bit together. A write that clears the enable bit takes effect only during the four clock cycles that follow the unlock write. The turn-off-enable bit clears itself when that window ends.

The prescale lengths are built from a base shift parameter, so a bench can use short periods. Each code step still doubles the period.

Top module: `wdt_guard`

## Requirements
- R1: The control word is five bits wide. Bit 4 is turn-off-enable, bit 3 is enable and bits 2:0 are the prescale code. A write stores the code, and `rd_data` returns {turn-off-enable, enable, code} from the cycle after the write.
- R2: A write with bits 4 and 3 both set sets the enable bit and turn-off-enable, even if enable was already 1.
- R3: After an unlock write, turn-off-enable reads 1 for exactly four cycles and then reads 0, unless a new unlock write restarts the window.
- R4: A write with bit 3 clear, made in any of the four cycles that follow an unlock write, clears the enable bit.
- R5: A write with bit 3 clear, made while turn-off-enable reads 0, leaves the enable bit at 1. The same write still updates the prescale code.
- R6: Code k selects a period of 2^(BASE_SHIFT+k) ticks. With the default BASE_SHIFT of 14, this spans 16K to 2048K ticks. A reset request follows the tick that completes the period.
- R7: The counter advances only on cycles where `tick_en` is high and the enable bit is 1. Otherwise it holds its value.
- R8: A service pulse clears the counter. It takes precedence over a tick in the same cycle, even a tick that would complete the period, so no request follows that cycle.
- R9: Setting the enable bit does not clear the counter. Counting resumes from the value held while disabled.
- R10: `wdt_rst_req` is high for exactly one cycle per expiry, and the counter returns to zero at the expiry.
- R11: The synchronous reset `rst` clears the enable bit, turn-off-enable, the prescale code, the counter and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle tick from the watchdog oscillator |
| svc | input | 1 | Service pulse that clears the counter |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Control write data: {turn-off-enable, enable, code[2:0]} |
| rd_data | output | 5 | Control register read-back |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
The interesting collision is a service pulse that arrives in the same cycle as the tick that would complete the period. The bench provokes it by driving the period minus one ticks and then raising `svc` and `tick_en` together. It judges the outcome by two things: no request may appear after that edge, and a full further period of ticks must be needed before the next request. A second collision is a disabling write that lands on the last cycle of the unlock window, or on the first cycle after it. The bench checks the read-back enable bit after each of these writes. A behavioural model is compared against the read-back and the request on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W     = 3;
  localparam int CTRL_W   = PS_W + 2;
  localparam int TOE_BIT  = PS_W + 1;
  localparam int EN_BIT   = PS_W;

  typedef struct packed {
    logic            toe;
    logic            en;
    logic [PS_W-1:0] ps;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic open
);
  localparam int LW = $clog2(WIN + 2);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (arm)         left <= LW'(WIN);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign open = (left != '0);

  // independent span counter: cycles elapsed since the last arm
  logic [LW-1:0] span;
  always_ff @(posedge clk) begin
    if (rst)                   span <= LW'(WIN + 1);
    else if (arm)              span <= '0;
    else if (span != LW'(WIN + 1)) span <= span + 1'b1;
  end

  assert_window_len_R3: assert property (@(posedge clk) disable iff (rst)
    open |-> (span < LW'(WIN)));
  assert_window_opens_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> open);
  assert_window_stays_shut_R3: assert property (@(posedge clk) disable iff (rst)
    (!open && !arm) |=> !open);
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output wdt_ctrl_t         ctrl
);
  logic            en_q;
  logic [PS_W-1:0] ps_q;
  logic            open;
  logic            arm;

  assign arm = wr_en && wr_data[TOE_BIT] && wr_data[EN_BIT];

  wdt_window #(.WIN(WIN)) u_window (
    .clk  (clk),
    .rst  (rst),
    .arm  (arm),
    .open (open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      ps_q <= '0;
    end else if (wr_en) begin
      ps_q <= wr_data[PS_W-1:0];
      if (wr_data[EN_BIT])  en_q <= 1'b1;
      else if (open)        en_q <= 1'b0;
    end
  end

  assign ctrl.toe = open;
  assign ctrl.en  = en_q;
  assign ctrl.ps  = ps_q;

  assert_unlock_sets_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (ctrl.en && ctrl.toe));
  assert_disable_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    (open && wr_en && !wr_data[EN_BIT]) |=> !ctrl.en);
  assert_locked_en_R5: assert property (@(posedge clk) disable iff (rst)
    (en_q && !open && wr_en && !wr_data[EN_BIT]) |=> ctrl.en);
  assert_code_stored_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl.ps == $past(wr_data[PS_W-1:0])));
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 14,
  parameter int CNT_W      = BASE_SHIFT + (1 << PS_W) - 1
) (
  input  logic [PS_W-1:0]  ps,
  output logic [CNT_W-1:0] limit
);
  localparam int NCODE = 1 << PS_W;

  logic [CNT_W-1:0] lims [NCODE];

  for (genvar k = 0; k < NCODE; k++) begin : g_lim
    assign lims[k] = CNT_W'((64'd1 << (BASE_SHIFT + k)) - 64'd1);
  end

  assign limit = lims[ps];
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             svc,
  input  logic [CNT_W-1:0] limit,
  output logic             req
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      req <= 1'b0;
    end else begin
      req <= 1'b0;
      if (svc) begin
        cnt <= '0;
      end else if (en && tick) begin
        if (cnt >= limit) begin
          cnt <= '0;
          req <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  assert_svc_wins_R8: assert property (@(posedge clk) disable iff (rst)
    svc |=> (cnt == '0 && !req));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!svc && !(en && tick)) |=> ($stable(cnt) && !req));
  assert_expiry_zero_R10: assert property (@(posedge clk) disable iff (rst)
    req |-> (cnt == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 14,
  parameter int WIN        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              svc,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              wdt_rst_req
);
  localparam int CNT_W = BASE_SHIFT + (1 << PS_W) - 1;

  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] limit;

  wdt_ctrl_reg #(.WIN(WIN)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  wdt_period_sel #(.BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_sel (
    .ps    (ctrl.ps),
    .limit (limit)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl.en),
    .tick  (tick_en),
    .svc   (svc),
    .limit (limit),
    .req   (wdt_rst_req)
  );

  assign rd_data = ctrl;

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !wdt_rst_req));
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B          = 2;
  localparam int WIN        = 4;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       svc = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic       wdt_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard #(.BASE_SHIFT(B), .WIN(WIN)) u_wdt_guard (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .svc         (svc),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .wdt_rst_req (wdt_rst_req)
  );

  // behavioural reference model
  int m_en, m_ps, m_win, m_cnt, m_req;
  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_ps = 0; m_win = 0; m_cnt = 0; m_req = 0;
    end else begin
      int was_open, old_ps, old_en;
      was_open = (m_win > 0);
      old_ps   = m_ps;
      old_en   = m_en;
      m_req    = 0;
      if (svc) m_cnt = 0;
      else if (old_en != 0 && tick_en) begin
        if (m_cnt + 1 >= (1 << (B + old_ps))) begin
          m_cnt = 0; m_req = 1;
        end else m_cnt = m_cnt + 1;
      end
      if (m_win > 0) m_win = m_win - 1;
      if (wr_en) begin
        m_ps = int'(wr_data[2:0]);
        if (wr_data[4] && wr_data[3]) begin m_en = 1; m_win = WIN; end
        else if (wr_data[3]) m_en = 1;
        else if (was_open != 0) m_en = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      int exp_rd;
      exp_rd = ((m_win > 0) ? 16 : 0) + (m_en * 8) + m_ps;
      chk(rd_data === 5'(exp_rd), "R1 model read-back", int'(rd_data), exp_rd);
      chk(wdt_rst_req === (m_req != 0), "R6 model request", int'(wdt_rst_req), m_req);
    end
  end

  task automatic write_ctrl(input logic [4:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count_to_pulse(input int maxc, input bit alt, output int ticks);
    int n = 0;
    ticks = -1;
    for (int i = 0; i < maxc; i++) begin
      tick_en = alt ? (i % 2 == 0) : 1'b1;
      if (tick_en) n++;
      @(negedge clk);
      if (wdt_rst_req) begin ticks = n; break; end
    end
    tick_en = 1'b0;
  endtask

  initial begin
    int t;
    repeat (2) @(negedge clk);
    chk(rd_data == 5'h00 && !wdt_rst_req, "R11 reset state", int'(rd_data), 0);
    rst = 1'b0;

    // R1: layout and read-back
    write_ctrl(5'h0A);
    chk(rd_data == 5'h0A, "R1 read-back", int'(rd_data), 10);

    // R6: code 2 -> 16 ticks
    count_to_pulse(100, 0, t);
    chk(t == 16, "R6 period code 2", t, 16);
    @(negedge clk);
    chk(!wdt_rst_req, "R10 single-cycle request", int'(wdt_rst_req), 0);

    // R6: code 0 -> 4 ticks, counter restarted at zero (R10)
    write_ctrl(5'h08);
    count_to_pulse(100, 0, t);
    chk(t == 4, "R10 restart from zero, R6 code 0", t, 4);

    // R7: gapped ticks
    count_to_pulse(100, 1, t);
    chk(t == 4, "R7 gapped ticks", t, 4);

    // R8: service collides with the expiring tick
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    svc = 1'b1;
    @(negedge clk);
    svc = 1'b0; tick_en = 1'b0;
    chk(!wdt_rst_req, "R8 service beats expiry", int'(wdt_rst_req), 0);
    count_to_pulse(100, 0, t);
    chk(t == 4, "R8 full period after service", t, 4);

    // R6: largest code
    write_ctrl(5'h0F);
    count_to_pulse(1000, 0, t);
    chk(t == 512, "R6 period code 7", t, 512);

    // R5: disable write with window closed
    write_ctrl(5'h03);
    chk(rd_data == 5'h0B, "R5 enable kept, code updated", int'(rd_data), 11);

    // R2, R3: unlock window length
    write_ctrl(5'h1B);
    for (int i = 0; i < WIN; i++) begin
      chk(rd_data[4:3] == 2'b11, "R2 R3 window open", int'(rd_data[4:3]), 3);
      @(negedge clk);
    end
    chk(rd_data[4] == 1'b0, "R3 window self-closes", int'(rd_data[4]), 0);

    // R5: one cycle too late
    write_ctrl(5'h03);
    chk(rd_data == 5'h0B, "R5 late disable ignored", int'(rd_data), 11);

    // R4: disable on last window cycle
    write_ctrl(5'h1B);
    repeat (WIN - 1) @(negedge clk);
    write_ctrl(5'h03);
    chk(rd_data == 5'h03, "R4 disable in window", int'(rd_data), 3);

    // R9: resume from held count
    write_ctrl(5'h08);
    svc = 1'b1; @(negedge clk); svc = 1'b0;
    tick_en = 1'b1; repeat (2) @(negedge clk); tick_en = 1'b0;
    write_ctrl(5'h18);
    write_ctrl(5'h00);
    chk(rd_data[3] == 1'b0, "R4 disabled", int'(rd_data[3]), 0);
    t = 0;
    tick_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wdt_rst_req) t++;
    end
    tick_en = 1'b0;
    chk(t == 0, "R7 no count while disabled", t, 0);
    write_ctrl(5'h08);
    count_to_pulse(100, 0, t);
    chk(t == 2, "R9 resume from held value", t, 2);

    // R11: reset mid-operation
    write_ctrl(5'h1F);
    rst = 1'b1;
    @(negedge clk);
    chk(rd_data == 5'h00 && !wdt_rst_req, "R11 reset clears", int'(rd_data), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule